// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns single read or write requests from inside the chip into timed cycles on an external memory bus. A request arrives on a valid/ready channel. It carries an address, write data, a word-or-byte flag and a configuration word that sets the timing and bus format for that access only. The sequencer drives an address latch strobe, read and write strobes, an output enable for the shared address/data lane, the lane itself and a separate address port. When the cycle is over, it returns a response on a second valid/ready channel.

The configuration word selects one of two things. In local-only operation the bus stays quiet. Otherwise there are four external formats: a 16-bit or 8-bit data lane, with the address either on its own port or shared in time with the data lane. The configuration word also sets the address width, the length of the latch strobe, an optional delay before the strobe, the wait states, an optional recovery cycle at the end, and whether a slow device may stretch the strobe through a ready input.

Back-pressure rules are as follows. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while no access is in progress. A response stays valid, with stable data, until `rsp_ready` is seen high. No new request is taken before that.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` is 0. `req_ready` is 1 only when no access is in progress. `rsp_valid` with unchanged `rsp_rdata` holds until `rsp_ready` is 1, and during that time `req_ready` stays 0.
- R2: With configuration bit 10 at 0 (local-only), an accepted request produces no latch strobe, no read or write strobe and no lane enable. The response is valid in the next cycle with data 0.
- R3: Each external byte or word cycle runs through these phases in order. Latch strobe lasts 1 cycle, or 2 cycles if bit 4 is set. Address hold lasts 1 cycle. The delay phase lasts 1 cycle if bit 5 is set. The strobe lasts 1 plus bits 3:0 cycles. Recovery lasts 1 cycle if bit 6 is set. The response becomes valid in the cycle after the last phase.
- R4: With bit 7 set, the strobe is held past its last wait state for as long as `bus_rdy` is 0. With bit 7 clear, `bus_rdy` has no effect.
- R5: Bits 9:8 select the address width: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. Address bits at or above that width are driven as 0.
- R6: Bits 12:11 select the bus format: 0 is 16-bit separate-address, 1 is 16-bit shared, 2 is 8-bit shared and 3 is 8-bit separate-address. In the separate-address formats, `bus_addr` carries the full masked address during every phase, and the lane is not enabled in the latch or hold phases.
- R7: In the shared formats, during the latch and hold phases `bus_ad_oe` is 1 and `bus_ad_out` carries the low 16 masked address bits. During every phase, `bus_addr` carries only the bits from 16 up, with its low 16 bits at 0.
- R8: For writes, `bus_wr` is high in the strobe phase. In the delay and strobe phases `bus_ad_oe` is 1 and the lane carries the data: the full word on a 16-bit lane, or the current byte in bits 7:0 with bits 15:8 at 0 on an 8-bit lane. A write response carries data 0.
- R9: For reads, `bus_rd` is high in the strobe phase and `bus_ad_oe` is 0 from the delay phase onward. `bus_ad_in` is sampled in the final strobe cycle. On a 16-bit lane the response data is that sample.
- R10: On an 8-bit lane with `req_word` at 1, two complete cycles run. The first is at the address and carries the low byte. The second is at the address plus one (then masked) and carries the high byte. Read bytes come from `bus_ad_in[7:0]`. With `req_word` at 0 a single byte cycle runs and response bits 15:8 are 0. On a 16-bit lane `req_word` has no effect.
- R11: The latch strobe never overlaps a read or write strobe, and the read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_word | input | 1 | 1 for a 16-bit access, 0 for a byte |
| req_addr | input | 24 | Access address |
| req_wdata | input | 16 | Write data |
| req_cfg | input | 13 | Per-access configuration word |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_rdata | output | 16 | Read data, 0 for writes |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_ad_oe | output | 1 | Lane output enable |
| bus_ad_out | output | 16 | Lane output value |
| bus_ad_in | input | 16 | Lane input value |
| bus_addr | output | 24 | Separate address port |
| bus_rdy | input | 1 | Ready from a slow device |

## Verification
A wrong phase or a bad wait-state count shows up as a response arriving early or late by whole cycles. It also changes the number of latch-strobe and strobe cycles counted on the pins within the same access. A wrong byte index or a bad address mask shows at the second latch strobe of a split access, as the wrong address or lane byte, and then as a swapped or zeroed response half. A lost ready stretch or a dropped response hold is seen one cycle after the event, as a strobe that ends early or a response that vanishes.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  localparam int WAIT_W = 4;

  // Field order sets the bit positions of the configuration word (MSB first).
  typedef struct packed {
    logic [1:0]        mode;    // 12:11 bus format
    logic              ext;     // 10    external access enabled
    logic [1:0]        aw;      // 9:8   address width select
    logic              rdy_en;  // 7     ready stretching
    logic              rcv;     // 6     recovery cycle
    logic              dly;     // 5     delay before strobe
    logic              ale2;    // 4     two-cycle latch strobe
    logic [WAIT_W-1:0] waits;   // 3:0   wait states
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic [2:0] {
    PH_IDLE, PH_ALE, PH_HOLD, PH_DLY, PH_STRB, PH_RCV, PH_DONE
  } ph_e;

  function automatic int aw_bits(input logic [1:0] aw);
    case (aw)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/ebs_phase_ctrl.sv
module ebs_phase_ctrl
  import ebs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  cfg_t cfg,
  input  logic split,
  input  logic rdy,
  input  logic rsp_ready,
  output ph_e  phase,
  output logic byte_sel,
  output logic strb_end
);
  logic [WAIT_W-1:0] cnt;
  logic cnt_zero, stall, last_byte;
  ph_e  tail;

  always_comb begin
    cnt_zero  = (cnt == '0);
    stall     = cfg.rdy_en && !rdy;
    strb_end  = (phase == PH_STRB) && cnt_zero && !stall;
    last_byte = !split || byte_sel;
    tail      = last_byte ? PH_DONE : PH_ALE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      byte_sel <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          byte_sel <= 1'b0;
          if (cfg.ext) begin
            phase <= PH_ALE;
            cnt   <= WAIT_W'(cfg.ale2);
          end else begin
            phase <= PH_DONE;
          end
        end
        PH_ALE: begin
          if (!cnt_zero) cnt <= cnt - 1'b1;
          else           phase <= PH_HOLD;
        end
        PH_HOLD: begin
          if (cfg.dly) phase <= PH_DLY;
          else begin
            phase <= PH_STRB;
            cnt   <= cfg.waits;
          end
        end
        PH_DLY: begin
          phase <= PH_STRB;
          cnt   <= cfg.waits;
        end
        PH_STRB: begin
          if (!cnt_zero) cnt <= cnt - 1'b1;
          else if (!stall) begin
            if (cfg.rcv) phase <= PH_RCV;
            else begin
              phase <= tail;
              cnt   <= WAIT_W'(cfg.ale2);
              if (!last_byte) byte_sel <= 1'b1;
            end
          end
        end
        PH_RCV: begin
          phase <= tail;
          cnt   <= WAIT_W'(cfg.ale2);
          if (!last_byte) byte_sel <= 1'b1;
        end
        PH_DONE: if (rsp_ready) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ebs_pin_mux.sv
module ebs_pin_mux
  import ebs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  ph_e               phase,
  input  logic              write,
  input  logic              mux,
  input  logic              bus8,
  input  logic              byte_sel,
  input  logic [ADDR_W-1:0] addr_cur,
  input  logic [DATA_W-1:0] wdata,
  output logic              ale,
  output logic              rd,
  output logic              wr,
  output logic              ad_oe,
  output logic [DATA_W-1:0] ad_out,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int BYTE_W = DATA_W / 2;

  logic active, addr_ph, data_ph;
  logic [DATA_W-1:0] lane;

  always_comb begin
    active  = phase inside {PH_ALE, PH_HOLD, PH_DLY, PH_STRB, PH_RCV};
    addr_ph = phase inside {PH_ALE, PH_HOLD};
    data_ph = write && (phase inside {PH_DLY, PH_STRB});
    lane    = bus8 ? {{BYTE_W{1'b0}},
                      byte_sel ? wdata[DATA_W-1:BYTE_W] : wdata[BYTE_W-1:0]}
                   : wdata;
    ale      = (phase == PH_ALE);
    rd       = (phase == PH_STRB) && !write;
    wr       = (phase == PH_STRB) && write;
    addr_out = '0;
    ad_out   = '0;
    ad_oe    = 1'b0;
    if (active)
      addr_out = mux ? {addr_cur[ADDR_W-1:DATA_W], {DATA_W{1'b0}}} : addr_cur;
    if (mux && addr_ph) begin
      ad_oe  = 1'b1;
      ad_out = addr_cur[DATA_W-1:0];
    end else if (data_ph) begin
      ad_oe  = 1'b1;
      ad_out = lane;
    end
  end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CFG_W-1:0]  req_cfg,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_ale,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_ad_oe,
  output logic [DATA_W-1:0] bus_ad_out,
  input  logic [DATA_W-1:0] bus_ad_in,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rdy
);
  localparam int BYTE_W = DATA_W / 2;

  cfg_t cfg_q, cfg_in, cfg_use;
  logic we_q, word_q, accept, bus8, mux, split;
  logic [ADDR_W-1:0] addr_q, addr_nxt, addr_cur;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  ph_e  phase;
  logic byte_sel, strb_end;

  always_comb begin
    cfg_in    = cfg_t'(req_cfg);
    req_ready = (phase == PH_IDLE);
    accept    = req_valid && req_ready;
    cfg_use   = (phase == PH_IDLE) ? cfg_in : cfg_q;
    bus8      = cfg_q.mode[1];
    mux       = (cfg_q.mode == 2'd1) || (cfg_q.mode == 2'd2);
    split     = bus8 && word_q;
    addr_nxt  = addr_q + ADDR_W'(byte_sel);
    rsp_valid = (phase == PH_DONE);
    rsp_rdata = rdata_q;
  end

  for (genvar g = 0; g < ADDR_W; g++) begin : g_amask
    assign addr_cur[g] = (g < aw_bits(cfg_q.aw)) ? addr_nxt[g] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      we_q    <= 1'b0;
      word_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (accept) begin
      cfg_q   <= cfg_in;
      we_q    <= req_write;
      word_q  <= req_word;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      rdata_q <= '0;
    end else if (strb_end && !we_q) begin
      if (!bus8)         rdata_q <= bus_ad_in;
      else if (byte_sel) rdata_q[DATA_W-1:BYTE_W] <= bus_ad_in[BYTE_W-1:0];
      else               rdata_q[BYTE_W-1:0] <= bus_ad_in[BYTE_W-1:0];
    end
  end

  ebs_phase_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(accept), .cfg(cfg_use), .split(split),
    .rdy(bus_rdy), .rsp_ready(rsp_ready), .phase(phase),
    .byte_sel(byte_sel), .strb_end(strb_end)
  );

  ebs_pin_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .phase(phase), .write(we_q), .mux(mux), .bus8(bus8), .byte_sel(byte_sel),
    .addr_cur(addr_cur), .wdata(wdata_q), .ale(bus_ale), .rd(bus_rd),
    .wr(bus_wr), .ad_oe(bus_ad_oe), .ad_out(bus_ad_out), .addr_out(bus_addr)
  );
endmodule

// File: rtl/ebs_checker.sv
module ebs_checker #(
  parameter int DATA_W = 16,
  parameter int CFG_W  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CFG_W-1:0]  req_cfg,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              bus_ale,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_ad_oe,
  input logic              bus_rdy,
  input logic              rdy_en_q
);
  p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_rsp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // bit 10 of the configuration word enables external access
  p_local_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_cfg[10] |=> rsp_valid && !bus_ale);

  p_rdy_stretch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) && rdy_en_q && !bus_rdy |=> (bus_rd || bus_wr));

  p_read_lane_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> !bus_ad_oe);

  p_ale_apart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> !(bus_rd || bus_wr));

  p_strobes_apart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
endmodule

bind ext_bus_seq ebs_checker #(.DATA_W(DATA_W), .CFG_W(ebs_pkg::CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_cfg(req_cfg), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .bus_ale(bus_ale), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_ad_oe(bus_ad_oe), .bus_rdy(bus_rdy), .rdy_en_q(cfg_q.rdy_en)
);

// File: tb/tb_ext_bus_seq.sv
`timescale 1ns/1ps
module tb_ext_bus_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [12:0] req_cfg = '0;
  logic        rsp_ready = 1'b1, bus_rdy = 1'b1;
  logic [15:0] bus_ad_in = '0;
  logic        req_ready, rsp_valid, bus_ale, bus_rd, bus_wr, bus_ad_oe;
  logic [15:0] rsp_rdata, bus_ad_out;
  logic [23:0] bus_addr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_bus_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_cfg(req_cfg), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .bus_ale(bus_ale),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ad_oe(bus_ad_oe),
    .bus_ad_out(bus_ad_out), .bus_ad_in(bus_ad_in), .bus_addr(bus_addr),
    .bus_rdy(bus_rdy)
  );

  typedef struct packed {
    logic [12:0] cfg;
    logic        we;
    logic        word;
    logic [23:0] addr;
    logic [15:0] wdata;
    logic [15:0] din;
    logic [3:0]  stall;
  } vec_t;

  // cfg = {mode[1:0], ext, aw[1:0], rdy_en, rcv, dly, ale2, waits[3:0]}
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{ {2'd0,1'b1,2'd3,1'b0,1'b0,1'b0,1'b0,4'd2},  1'b1, 1'b1, 24'h123456, 16'hA55A, 16'h0000, 4'd0 },
    '{ {2'd1,1'b1,2'd0,1'b0,1'b0,1'b1,1'b1,4'd1},  1'b0, 1'b1, 24'hABCDEF, 16'h0000, 16'h1234, 4'd0 },
    '{ {2'd2,1'b1,2'd1,1'b0,1'b1,1'b0,1'b0,4'd0},  1'b0, 1'b1, 24'h07FFFF, 16'h0000, 16'hBEEF, 4'd0 },
    '{ {2'd3,1'b1,2'd2,1'b0,1'b1,1'b1,1'b0,4'd0},  1'b1, 1'b1, 24'h123456, 16'hC3A5, 16'h0000, 4'd0 },
    '{ {2'd3,1'b1,2'd3,1'b0,1'b0,1'b0,1'b0,4'd1},  1'b0, 1'b0, 24'h00F0F1, 16'h0000, 16'h77E1, 4'd0 },
    '{ {2'd1,1'b1,2'd3,1'b1,1'b0,1'b0,1'b0,4'd0},  1'b0, 1'b1, 24'hFEDCBA, 16'h0000, 16'h4C2D, 4'd3 },
    '{ {2'd0,1'b1,2'd3,1'b0,1'b0,1'b0,1'b0,4'd0},  1'b0, 1'b1, 24'h000100, 16'h0000, 16'h6E6E, 4'd3 },
    '{ {2'd1,1'b0,2'd3,1'b0,1'b0,1'b0,1'b0,4'd2},  1'b0, 1'b1, 24'h00AAAA, 16'h0000, 16'hFFFF, 4'd0 },
    '{ {2'd0,1'b1,2'd1,1'b0,1'b1,1'b0,1'b1,4'd0},  1'b0, 1'b1, 24'h3FFFFF, 16'h0000, 16'h8421, 4'd0 },
    '{ {2'd2,1'b1,2'd2,1'b0,1'b0,1'b0,1'b0,4'd15}, 1'b1, 1'b0, 24'h0ABCDE, 16'h9966, 16'h0000, 4'd0 }
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] amask(input logic [23:0] a, input logic [1:0] aw);
    case (aw)
      2'd0:    return a & 24'h00FFFF;
      2'd1:    return a & 24'h03FFFF;
      2'd2:    return a & 24'h0FFFFF;
      default: return a;
    endcase
  endfunction

  task automatic do_access(input vec_t v, input int idx);
    logic [1:0] mode = v.cfg[12:11];
    logic ext = v.cfg[10], rdy_en = v.cfg[7], rcv = v.cfg[6];
    logic dly = v.cfg[5], ale2 = v.cfg[4];
    logic [3:0] waits = v.cfg[3:0];
    logic bus8 = mode[1];
    logic mux = (mode == 2'd1) || (mode == 2'd2);
    int bytes = !ext ? 0 : ((bus8 && v.word) ? 2 : 1);
    int per = 1 + ale2 + 1 + dly + 1 + waits + rcv;
    int exp_n = bytes * per + ((ext && rdy_en) ? v.stall : 0);
    logic [23:0] m0 = amask(v.addr, v.cfg[9:8]);
    logic [23:0] m1 = amask(v.addr + 24'd1, v.cfg[9:8]);
    logic [15:0] exp_rd;
    int n = 0, ale_cyc = 0, strb = 0, rises = 0, wrs = 0;
    logic prev_ale = 1'b0, badoe = 1'b0, ovl = 1'b0;
    logic [23:0] a0_addr = '0, a1_addr = '0;
    logic [15:0] a0_ad = '0, a1_ad = '0, wd0 = '0, wd1 = '0;
    logic a0_oe = 1'b0, a1_oe = 1'b0, wo0 = 1'b0, wo1 = 1'b0;
    string t;
    if (v.we || !ext)          exp_rd = 16'h0000;
    else if (!bus8)            exp_rd = v.din;
    else if (v.word)           exp_rd = v.din;
    else                       exp_rd = {8'h00, v.din[7:0]};

    @(negedge clk);
    req_cfg = v.cfg; req_write = v.we; req_word = v.word;
    req_addr = v.addr; req_wdata = v.wdata; req_valid = 1'b1;
    rsp_ready = 1'b1; bus_rdy = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && n < 500) begin
      logic rise;
      rise = bus_ale && !prev_ale;
      prev_ale = bus_ale;
      if (rise) begin
        rises++;
        if (rises == 1) begin a0_addr = bus_addr; a0_ad = bus_ad_out; a0_oe = bus_ad_oe; end
        if (rises == 2) begin a1_addr = bus_addr; a1_ad = bus_ad_out; a1_oe = bus_ad_oe; end
      end
      if (bus_ale) ale_cyc++;
      if (bus_ale && (bus_rd || bus_wr)) ovl = 1'b1;
      if (bus_rd || bus_wr) begin
        strb++;
        if (bus_wr) wrs++;
        if (bus_rd && bus_ad_oe) badoe = 1'b1;
        if (rises <= 1) begin wd0 = bus_ad_out; wo0 = bus_ad_oe; end
        else begin wd1 = bus_ad_out; wo1 = bus_ad_oe; end
        bus_rdy = (strb > v.stall);
      end else begin
        bus_rdy = 1'b1;
      end
      if (bus8) bus_ad_in = (rises >= 2) ? {8'h5A, v.din[15:8]} : {8'hA5, v.din[7:0]};
      else      bus_ad_in = v.din;
      n++;
      @(negedge clk);
    end
    bus_rdy = 1'b1;
    t = $sformatf("v%0d", idx);
    chk({t, " R3 R4 latency"}, n, exp_n);
    chk({t, " R3 latch cycles"}, ale_cyc, bytes * (1 + ale2));
    chk({t, " R2 R10 cycle count"}, rises, bytes);
    chk({t, " R9 R10 R8 R2 response data"}, rsp_rdata, exp_rd);
    chk({t, " R11 overlap"}, ovl, 1'b0);
    if (ext) begin
      if (mux) begin
        chk({t, " R7 R5 upper address"}, a0_addr, {m0[23:16], 16'h0000});
        chk({t, " R7 R5 lane address"}, a0_ad, m0[15:0]);
        chk({t, " R7 lane enable at latch"}, a0_oe, 1'b1);
      end else begin
        chk({t, " R6 R5 address port"}, a0_addr, m0);
        chk({t, " R6 lane idle at latch"}, a0_oe, 1'b0);
      end
      if (bytes == 2) begin
        if (mux) begin
          chk({t, " R10 R7 second upper address"}, a1_addr, {m1[23:16], 16'h0000});
          chk({t, " R10 R7 second lane address"}, a1_ad, m1[15:0]);
          chk({t, " R10 second lane enable"}, a1_oe, 1'b1);
        end else begin
          chk({t, " R10 R6 second address"}, a1_addr, m1);
        end
      end
      if (v.we) begin
        chk({t, " R8 write strobes"}, wrs, strb);
        chk({t, " R8 lane enable"}, wo0, 1'b1);
        chk({t, " R8 first data"}, wd0, bus8 ? {8'h00, v.wdata[7:0]} : v.wdata);
        if (bytes == 2) chk({t, " R10 R8 second data"}, wd1, {8'h00, v.wdata[15:8]});
      end else begin
        chk({t, " R9 no write strobe"}, wrs, 0);
        chk({t, " R9 lane off in read"}, badoe, 1'b0);
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk({t, " R1 ready after response"}, req_ready, 1'b1);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset req_ready", req_ready, 1'b1);
    chk("R1 reset rsp_valid", rsp_valid, 1'b0);
    chk("R11 reset strobes", {bus_ale, bus_rd, bus_wr}, 3'b000);
    chk("R6 reset lane enable", bus_ad_oe, 1'b0);
    chk("R6 reset address", bus_addr, 24'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) do_access(VECS[i], i);

    // Response back-pressure: demux16 read, no waits
    @(negedge clk);
    req_cfg = {2'd0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0};
    req_write = 1'b0; req_word = 1'b1; req_addr = 24'h000042;
    bus_ad_in = 16'h9A3C; rsp_ready = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 busy not ready", req_ready, 1'b0);
    for (int k = 0; k < 10 && !rsp_valid; k++) @(negedge clk);
    bus_ad_in = 16'h0000;
    for (int k = 0; k < 4; k++) begin
      chk("R1 response held", rsp_valid, 1'b1);
      chk("R1 response data stable", rsp_rdata, 16'h9A3C);
      chk("R1 no new accept", req_ready, 1'b0);
      chk("R1 bus quiet while held", {bus_ale, bus_rd, bus_wr}, 3'b000);
      @(negedge clk);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R1 released", {req_ready, rsp_valid}, 2'b10);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule